// File: doc/BRIEF.md
# Four-Level Priority Interrupt Controller

This block sits beside a small 8-bit processor core and decides when the core must break off its program to serve a peripheral. It takes eleven request lines, latches each into its own flag, and holds an enable bit per source, a master enable, and a two-bit level per source. On each machine-cycle strobe it looks for the most urgent pending source that may run. At an instruction boundary it tells the core to force a subroutine call, and it gives the address to call.

Interrupts nest. A running service routine can only be interrupted by a source at a strictly higher level, so up to four routines can be active at once. A 4-bit in-service mask records which levels are active. A return-from-interrupt clears the highest active level. The forced call takes six machine cycles, and the block marks the cycle in which the core enters the vector.

Top module: `prio_irq_ctl`

## Requirements
- R1: A request that is present at a machine-cycle strobe sets that source's flag even when the source is disabled. The flag stays set, and the source is acknowledged once it is enabled.
- R2: Register 0 bit 7 is the master enable, and clearing it masks every source. Register 0 bit 6 has no effect on arbitration.
- R3: Among eligible sources, the highest level wins. Among equal levels, the lowest source index wins. The level of source i is {reg4/5 bit, reg2/3 bit}. Sources 0..7 use bit i of registers 2 and 4. Sources 8..10 use bit i-8 of registers 3 and 5. The enables use register 0 bits 5:0 for sources 0..5 and register 1 bits 4:0 for sources 6..10.
- R4: On acknowledge, `vec_addr` equals 0x0003 + 8 × source index, and the winner's flag is cleared, so that source is not served again without a new request.
- R5: An acknowledge happens only at a strobe on which `insn_end` is high.
- R6: An acknowledge is deferred at a boundary where `is_reti` is high, or where any register write happened during the instruction that is ending.
- R7: While a routine is active, only a source at a strictly higher level is acknowledged. A source at an equal or lower level waits.
- R8: `vec_go` pulses on the sixth strobe after the acknowledge strobe. No acknowledge occurs during those six cycles. The minimum latency from the strobe that samples a request to vector entry is therefore 7 machine cycles.
- R9: A return-from-interrupt at a boundary clears the highest in-service level, and the previous level becomes current again.
- R10: After reset, `ack`, `vec_go` and `svc_act` are 0 and `vec_addr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq | input | 11 | Request lines, sampled on strobe |
| mc_stb | input | 1 | Machine-cycle strobe |
| insn_end | input | 1 | Current machine cycle ends an instruction |
| is_reti | input | 1 | Ending instruction is a return-from-interrupt |
| wr_en | input | 1 | Write to an enable or level register |
| wr_addr | input | 3 | Register select, 0..5 |
| wr_data | input | 8 | Write data |
| ack | output | 1 | One-cycle pulse: force the call now |
| vec_addr | output | 16 | Call target of the last acknowledge |
| vec_go | output | 1 | One-cycle pulse: call complete, vector entered |
| svc_act | output | 1 | At least one routine in service |
| svc_lvl | output | 2 | Highest level in service |

## Verification
The assertions check the following properties on every cycle:
- an acknowledge only ever lands on an instruction boundary;
- an acknowledge never lands on a return or register-write boundary;
- an acknowledge never lands during a forced call;
- a nested acknowledge always raises the in-service level;
- each return drops exactly one in-service level.

Other properties need whole scenarios, which only the bench runs:
- a flag latched while its source was disabled is served once enabled;
- the master-enable bit and its unused neighbour behave as specified;
- the order of service for simultaneous requests at mixed levels;
- an equal-level request waits until the active routine returns;
- the seven-cycle latency.

// File: rtl/prio_irq_ctl.sv
`timescale 1ns/1ps
module prio_irq_ctl #(
  parameter int CALL_CYC = 6,
  parameter int VEC_BASE = 3,
  parameter int VEC_STEP = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [10:0] irq,
  input  logic        mc_stb,
  input  logic        insn_end,
  input  logic        is_reti,
  input  logic        wr_en,
  input  logic [2:0]  wr_addr,
  input  logic [7:0]  wr_data,
  output logic        ack,
  output logic [15:0] vec_addr,
  output logic        vec_go,
  output logic        svc_act,
  output logic [1:0]  svc_lvl
);
  localparam int N  = 11;
  localparam int CW = $clog2(CALL_CYC + 1);

  logic [N-1:0] flag, en, pl0, pl1;
  logic         glb, blk_wr;
  logic [3:0]   isr;
  logic [CW-1:0] cnt;
  logic         win_v;
  logic [3:0]   win_id;
  logic [1:0]   win_lvl;

  wire bnd    = mc_stb & insn_end;
  wire hold   = is_reti | wr_en | blk_wr;
  wire do_ack = bnd & ~hold & win_v & (cnt == '0);

  assign svc_act = |isr;

  always_comb begin
    svc_lvl = 2'd0;
    for (int l = 0; l < 4; l++)
      if (isr[l]) svc_lvl = 2'(l);
  end

  always_comb begin
    win_v = 1'b0; win_id = '0; win_lvl = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (flag[i] && en[i] && glb &&
          (!svc_act || {pl1[i], pl0[i]} > svc_lvl) &&
          (!win_v || {pl1[i], pl0[i]} >= win_lvl)) begin
        win_v = 1'b1; win_id = 4'(i); win_lvl = {pl1[i], pl0[i]};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      glb <= 1'b0; en <= '0; pl0 <= '0; pl1 <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        3'd0: begin glb <= wr_data[7]; en[5:0] <= wr_data[5:0]; end
        3'd1: en[10:6]  <= wr_data[4:0];
        3'd2: pl0[7:0]  <= wr_data;
        3'd3: pl0[10:8] <= wr_data[2:0];
        3'd4: pl1[7:0]  <= wr_data;
        3'd5: pl1[10:8] <= wr_data[2:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag <= '0; blk_wr <= 1'b0; isr <= '0; cnt <= '0;
      ack <= 1'b0; vec_go <= 1'b0; vec_addr <= '0;
    end else begin
      ack    <= do_ack;
      vec_go <= mc_stb && (cnt == CW'(1));
      if (bnd) blk_wr <= 1'b0;
      else if (wr_en) blk_wr <= 1'b1;
      if (mc_stb)
        flag <= (flag & ~(do_ack ? (N'(1) << win_id) : N'(0))) | irq;
      if (do_ack) begin
        cnt      <= CW'(CALL_CYC);
        isr      <= isr | (4'b1 << win_lvl);
        vec_addr <= 16'(VEC_BASE + VEC_STEP * int'(win_id));
      end else begin
        if (mc_stb && cnt != '0) cnt <= cnt - CW'(1);
        if (bnd && is_reti) isr <= isr & ~(4'b1 << svc_lvl);
      end
    end
  end

  p_ack_at_bnd_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> $past(mc_stb && insn_end));
  p_ack_not_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> !$past(is_reti) && !$past(wr_en));
  p_no_ack_in_call_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> $past(cnt == '0));
  p_strict_preempt_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && $past(svc_act)) |-> svc_lvl > $past(svc_lvl));
  p_reti_pops_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mc_stb && insn_end && is_reti && svc_act) |->
      $countones(isr) == $countones($past(isr)) - 1);
endmodule

// File: tb/sim_prio_irq_ctl.sv
`timescale 1ns/1ps
module sim_prio_irq_ctl;
  logic clk = 0, rst_n = 0;
  logic [10:0] irq = '0;
  logic mc_stb = 0, insn_end = 1, is_reti = 0, wr_en = 0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic ack, vec_go, svc_act;
  logic [15:0] vec_addr;
  logic [1:0] svc_lvl;

  int checks = 0, errs = 0, acks = 0;
  logic last_go;
  logic [15:0] q_vec[$];
  logic [1:0]  q_lvl[$];

  prio_irq_ctl u0 (.*);

  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin errs++; $display("FAIL %s actual=%0d expected=%0d", req, act, exp); end
  endtask

  task automatic expect_ack(input int src, input int lvl);
    q_vec.push_back(16'(3 + 8 * src));
    q_lvl.push_back(2'(lvl));
  endtask

  always @(negedge clk) if (rst_n && ack) begin
    acks++;
    if (q_vec.size() == 0) chk(0, "R7 unexpected ack", int'(vec_addr), 0);
    else begin
      logic [15:0] ev; logic [1:0] el;
      ev = q_vec.pop_front(); el = q_lvl.pop_front();
      chk(vec_addr == ev, "R3/R4 vector", int'(vec_addr), int'(ev));
      chk(svc_lvl == el && svc_act, "R7 level", int'(svc_lvl), int'(el));
    end
  end

  task automatic mcyc();
    @(negedge clk); mc_stb = 1;
    @(negedge clk); mc_stb = 0; last_go = vec_go;
  endtask
  task automatic run(input int n);
    for (int k = 0; k < n; k++) mcyc();
  endtask
  task automatic wr(input int a, input int d);
    @(negedge clk); wr_en = 1; wr_addr = 3'(a); wr_data = 8'(d);
    @(negedge clk); wr_en = 0;
  endtask
  task automatic req(input logic [10:0] m);
    irq = m; mcyc(); irq = '0;
  endtask
  task automatic reti();
    is_reti = 1; mcyc(); is_reti = 0;
  endtask

  initial begin
    #2000000;
    errs++; $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
    $finish;
  end

  initial begin
    int a0, lat;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!ack && !vec_go && !svc_act && vec_addr == 0, "R10 reset", int'(vec_addr), 0);
    // levels: src2,4,6,7=1  src9=2  src10=3
    wr(0, 8'hBF); wr(1, 8'h1F); wr(2, 8'hD4); wr(3, 8'h04); wr(4, 8'h00); wr(5, 8'h06);
    run(2);
    // R8 latency
    expect_ack(3, 0);
    req(11'h008);
    lat = 0;
    for (int k = 1; k <= 10; k++) begin mcyc(); if (last_go && lat == 0) lat = k; end
    chk(lat == 7, "R8 latency", lat, 7);
    reti();
    chk(!svc_act, "R9 return to idle", int'(svc_act), 0);
    // R1 flag held while disabled
    wr(0, 8'h9F); run(1);
    req(11'h020); run(4);
    chk(q_vec.size() == 0 && acks == 1, "R1 no ack while disabled", acks, 1);
    expect_ack(5, 0);
    wr(0, 8'hBF);
    a0 = acks; mcyc();
    chk(acks == a0, "R6 deferred after write", acks, a0);
    run(8); reti();
    chk(acks == a0 + 1, "R1 served once enabled", acks, a0 + 1);
    // R2 master enable and bit 6
    wr(0, 8'h7F); run(1);
    a0 = acks; req(11'h001); run(4);
    chk(acks == a0, "R2 master clear masks", acks, a0);
    expect_ack(0, 0);
    wr(0, 8'hBF); run(9); reti();
    chk(acks == a0 + 1, "R2 bit6 clear no effect", acks, a0 + 1);
    // R3 arbitration order
    expect_ack(9, 2);
    req(11'h286); run(8);
    a0 = acks; reti();
    chk(acks == a0, "R6 deferred on reti", acks, a0);
    expect_ack(2, 1); run(8); reti();
    expect_ack(7, 1); run(8); reti();
    expect_ack(1, 0); run(8); reti();
    chk(!svc_act && q_vec.size() == 0, "R3 all served", q_vec.size(), 0);
    // R7 / R9 nesting
    expect_ack(4, 1); req(11'h010); run(8);
    a0 = acks; req(11'h040); run(3);
    chk(acks == a0, "R7 equal level refused", acks, a0);
    expect_ack(10, 3); req(11'h400); run(8);
    chk(svc_lvl == 3, "R7 preempt level", int'(svc_lvl), 3);
    reti();
    chk(svc_act && svc_lvl == 1, "R9 restore level", int'(svc_lvl), 1);
    a0 = acks; run(2);
    chk(acks == a0, "R7 still blocked", acks, a0);
    reti();
    chk(!svc_act, "R9 idle", int'(svc_act), 0);
    expect_ack(6, 1); run(8); reti();
    // R4 flag cleared: no re-service
    a0 = acks; run(4);
    chk(acks == a0, "R4 flag cleared", acks, a0);
    // R5 boundary only
    insn_end = 0; a0 = acks;
    req(11'h008); run(3);
    chk(acks == a0, "R5 no ack mid-instruction", acks, a0);
    expect_ack(3, 0); insn_end = 1; run(8); reti();
    chk(q_vec.size() == 0, "R5 queue drained", q_vec.size(), 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
    $finish;
  end
endmodule